// File: doc/BRIEF.md
# I2C Bus-Clear Pulse Sequencer

This block frees an I2C bus when another device holds SDA low. It drives extra clock pulses onto the open-drain SCL line, one at a time, and watches the synchronised SDA level after each pulse. Software can ask for a single pulse through a control register write. A request bit stays set until that pulse has finished and then clears itself. Read-only monitor bits show the sampled levels of both bus lines.

A built-in sequencer can also run the whole recovery. It issues pulses until SDA reads high or the pulse limit is reached. After each pulse it clears any status flag that the pulse raised. When recovery succeeds, it pulses a reset to the protocol engine so that the engine is back in step with the bus. Bit-rate generation and full transfers belong to neighbouring logic.

Top module: `i2c_bus_clear`

## Requirements
- R1: A granted pulse request pulls SCL low (`scl_oe` = 1) for exactly HALF_CYC clock cycles and then releases it high for HALF_CYC cycles. Each request makes exactly one pulse.
- R2: Control bit 2 (pulse request) reads 1 while a manual pulse is in progress. It returns to 0 by itself once that pulse completes.
- R3: A request is granted only when the same control write also sets bit 0 (enable) to 1 and no pulse or recovery is running. A request made during a pulse, or with bit 0 at 0, produces no extra pulse.
- R4: Control bit 3 shows the SCL input level and bit 4 shows the SDA input level. Each passes through a two-flop synchroniser, so a change appears within 3 clock cycles.
- R5: Status bit 0 (arbitration-lost flag) is set when a pulse completes while synchronised SDA is low. A status write whose bit 0 is 0 clears the flag.
- R6: A `recover_go` pulse with enable set starts recovery. Recovery stops as soon as SDA reads high, so it issues exactly as many pulses as the holding device needs (zero if SDA is already high). It then sets `rec_ok`.
- R7: If SDA is still low after MAX_PULSES (9) pulses, recovery sets `rec_fail`, issues no further pulse, and gives no engine reset.
- R8: A successful recovery drives `eng_rst` high for exactly one clock cycle. Control bit 1 (engine reset) held at 1 by software also drives `eng_rst` high, and writing it back to 0 releases it.
- R9: During recovery, the status flags are cleared after every pulse, so the status register reads 0 when recovery ends.
- R10: The block never drives SCL high. `scl_oe` is 0 out of reset and outside a pulse's low phase, and `rec_busy`, `rec_ok` and `rec_fail` are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (bit0 enable, bit1 engine reset, bit2 pulse request) |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data; a 0 in bit 0 clears the arbitration-lost flag |
| recover_go | input | 1 | Starts automatic recovery |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Open-drain SCL pull-down enable |
| eng_rst | output | 1 | Reset to the protocol engine |
| ctrl_rdata | output | 8 | Control read-back (bit3 SCL monitor, bit4 SDA monitor) |
| stat_rdata | output | 8 | Status read-back (bit0 arbitration lost) |
| rec_busy | output | 1 | Recovery in progress |
| rec_ok | output | 1 | Last recovery freed SDA |
| rec_fail | output | 1 | Last recovery hit the pulse limit |

## Verification
Several properties are checked on every cycle:
- every SCL low phase lasts exactly HALF_CYC cycles;
- the request bit falls only after a pulse completes;
- the arbitration-lost flag rises only at the end of a pulse;
- a recovery never issues more than the pulse limit;
- success is declared only when SDA read high;
- the engine-reset pulse from the sequencer is one cycle wide.

Other behaviour needs the bench's scenarios. These cover the exact pulse count for each number of pulses the holding device needs, the boundary at exactly nine pulses against ten or more, requests that must be ignored, and the clearing of status both by a write of zero and by the sequencer.

// File: rtl/i2c_clr_pkg.sv
package i2c_clr_pkg;
  typedef enum logic [1:0] {PG_IDLE, PG_LOW, PG_HIGH} pg_state_t;
  typedef enum logic [1:0] {RC_IDLE, RC_CHECK, RC_WAIT, RC_RST} rc_state_t;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_ERST = 1;
  localparam int CTRL_REQ  = 2;
  localparam int CTRL_SCLM = 3;
  localparam int CTRL_SDAM = 4;
  localparam int STAT_ARB  = 0;
endpackage

// File: rtl/i2c_clr_sync.sv
module i2c_clr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d[gi]};
      end
      assign q[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_clr_pulse.sv
module i2c_clr_pulse
  import i2c_clr_pkg::*;
#(
  parameter int HALF_CYC = 4,
  localparam int CW = $clog2(HALF_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic scl_oe,
  output logic last_high,
  output logic done
);
  pg_state_t     state;
  logic [CW-1:0] cnt;

  assign busy      = (state != PG_IDLE);
  assign last_high = (state == PG_HIGH) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PG_IDLE;
      cnt    <= '0;
      scl_oe <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        PG_IDLE: if (start) begin
          state  <= PG_LOW;
          cnt    <= CW'(HALF_CYC - 1);
          scl_oe <= 1'b1;
        end
        PG_LOW: if (cnt == '0) begin
          state  <= PG_HIGH;
          cnt    <= CW'(HALF_CYC - 1);
          scl_oe <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PG_HIGH: if (cnt == '0) begin
          state <= PG_IDLE;
          done  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= PG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_clr_seq.sv
module i2c_clr_seq
  import i2c_clr_pkg::*;
#(
  parameter int MAX_PULSES = 9,
  localparam int NW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic enable,
  input  logic sda_hi,
  input  logic pulse_busy,
  input  logic pulse_done,
  output logic pulse_req,
  output logic stat_clr,
  output logic rst_pulse,
  output logic busy,
  output logic ok,
  output logic fail
);
  rc_state_t     state;
  logic [NW-1:0] n_sent;

  assign busy = (state != RC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RC_IDLE;
      n_sent    <= '0;
      pulse_req <= 1'b0;
      stat_clr  <= 1'b0;
      rst_pulse <= 1'b0;
      ok        <= 1'b0;
      fail      <= 1'b0;
    end else begin
      pulse_req <= 1'b0;
      stat_clr  <= 1'b0;
      case (state)
        RC_IDLE: if (go && enable && !pulse_busy) begin
          n_sent <= '0;
          ok     <= 1'b0;
          fail   <= 1'b0;
          state  <= RC_CHECK;
        end
        RC_CHECK: begin
          if (sda_hi) begin
            ok        <= 1'b1;
            rst_pulse <= 1'b1;
            state     <= RC_RST;
          end else if (n_sent == NW'(MAX_PULSES)) begin
            fail  <= 1'b1;
            state <= RC_IDLE;
          end else begin
            pulse_req <= 1'b1;
            n_sent    <= n_sent + 1'b1;
            state     <= RC_WAIT;
          end
        end
        RC_WAIT: if (pulse_done) begin
          stat_clr <= 1'b1;
          state    <= RC_CHECK;
        end
        RC_RST: begin
          rst_pulse <= 1'b0;
          state     <= RC_IDLE;
        end
        default: state <= RC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_clr_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [REG_W-1:0] ctrl_wdata,
  input  logic             stat_we,
  input  logic [REG_W-1:0] stat_wdata,
  input  logic             recover_go,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             eng_rst,
  output logic [REG_W-1:0] ctrl_rdata,
  output logic [REG_W-1:0] stat_rdata,
  output logic             rec_busy,
  output logic             rec_ok,
  output logic             rec_fail
);
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       en_q, erst_q, req_q, arb_q, eng_rst_q;
  logic       pg_busy, pg_last, pulse_done, pg_start;
  logic       seq_req, seq_clr, seq_rst, seq_go, manual_start;

  i2c_clr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sda_in, scl_in}), .q(line_s)
  );
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  assign manual_start = ctrl_we && ctrl_wdata[CTRL_REQ] && ctrl_wdata[CTRL_EN]
                        && !pg_busy && !rec_busy && !req_q && !seq_req;
  assign seq_go   = recover_go && !req_q && !manual_start;
  assign pg_start = manual_start || seq_req;

  i2c_clr_pulse #(.HALF_CYC(HALF_CYC)) u_pulse (
    .clk(clk), .rst(rst), .start(pg_start), .busy(pg_busy),
    .scl_oe(scl_oe), .last_high(pg_last), .done(pulse_done)
  );

  i2c_clr_seq #(.MAX_PULSES(MAX_PULSES)) u_seq (
    .clk(clk), .rst(rst), .go(seq_go), .enable(en_q), .sda_hi(sda_s),
    .pulse_busy(pg_busy), .pulse_done(pulse_done), .pulse_req(seq_req),
    .stat_clr(seq_clr), .rst_pulse(seq_rst), .busy(rec_busy),
    .ok(rec_ok), .fail(rec_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      erst_q    <= 1'b0;
      req_q     <= 1'b0;
      arb_q     <= 1'b0;
      eng_rst_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        en_q   <= ctrl_wdata[CTRL_EN];
        erst_q <= ctrl_wdata[CTRL_ERST];
      end
      if (manual_start)    req_q <= 1'b1;
      else if (pulse_done) req_q <= 1'b0;

      if (pg_last && !sda_s)                   arb_q <= 1'b1;
      else if (seq_clr)                        arb_q <= 1'b0;
      else if (stat_we && !stat_wdata[STAT_ARB]) arb_q <= 1'b0;

      eng_rst_q <= erst_q | seq_rst;
    end
  end

  assign eng_rst = eng_rst_q;

  always_comb begin
    ctrl_rdata            = '0;
    ctrl_rdata[CTRL_EN]   = en_q;
    ctrl_rdata[CTRL_ERST] = erst_q;
    ctrl_rdata[CTRL_REQ]  = req_q;
    ctrl_rdata[CTRL_SCLM] = scl_s;
    ctrl_rdata[CTRL_SDAM] = sda_s;
    stat_rdata            = '0;
    stat_rdata[STAT_ARB]  = arb_q;
  end
endmodule

// File: rtl/i2c_clr_chk.sv
module i2c_clr_chk #(
  parameter int HALF_CYC   = 4,
  parameter int MAX_PULSES = 9
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_oe,
  input logic       pulse_done,
  input logic       seq_rst,
  input logic [7:0] ctrl_rdata,
  input logic [7:0] stat_rdata,
  input logic       rec_busy,
  input logic       rec_ok,
  input logic       rec_fail
);
  logic [7:0] low_cnt;
  logic [7:0] rec_pulses;
  logic       oe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt    <= '0;
      rec_pulses <= '0;
      oe_d       <= 1'b0;
    end else begin
      oe_d <= scl_oe;
      if (scl_oe && low_cnt != 8'hff) low_cnt <= low_cnt + 1'b1;
      else if (!scl_oe)                low_cnt <= '0;
      if (!rec_busy)              rec_pulses <= '0;
      else if (scl_oe && !oe_d)   rec_pulses <= rec_pulses + 1'b1;
    end
  end

  // R1
  low_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> low_cnt == 8'(HALF_CYC));
  // R2
  req_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_rdata[2]) |-> $past(pulse_done));
  // R5
  arb_at_pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_rdata[0]) |-> pulse_done);
  // R6
  ok_needs_sda_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rec_ok) |-> $past(ctrl_rdata[4]));
  // R7
  pulse_limit_chk: assert property (@(posedge clk) disable iff (rst)
    rec_pulses <= 8'(MAX_PULSES));
  // R7
  fail_ends_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rec_fail) |-> !rec_busy && !seq_rst);
  // R8
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    seq_rst |=> !seq_rst);
endmodule

bind i2c_bus_clear i2c_clr_chk #(.HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .pulse_done(pulse_done),
  .seq_rst(seq_rst), .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata),
  .rec_busy(rec_busy), .rec_ok(rec_ok), .rec_fail(rec_fail)
);

// File: tb/i2c_bus_clear_bench.sv
`timescale 1ns/1ps
module i2c_bus_clear_bench;
  localparam int HALF = 4;
  localparam int MAXP = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0, stat_we = 1'b0, recover_go = 1'b0;
  logic [7:0] ctrl_wdata = '0, stat_wdata = '0;
  logic       scl_ext = 1'b1;
  logic       scl_in, sda_in, scl_oe, eng_rst, rec_busy, rec_ok, rec_fail;
  logic [7:0] ctrl_rdata, stat_rdata;

  int checks = 0, errors = 0;
  int hold_left = 0;
  int pulses = 0, low_w = 0, last_low = 0, rst_rises = 0;
  logic oe_prev = 1'b0, er_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_in = scl_ext & ~scl_oe;
  assign sda_in = (hold_left == 0);

  i2c_bus_clear u_i2c_bus_clear (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .recover_go(recover_go),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .eng_rst(eng_rst),
    .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata), .rec_busy(rec_busy),
    .rec_ok(rec_ok), .rec_fail(rec_fail)
  );

  // bus observer and model of the device holding SDA
  always @(negedge clk) begin
    if (scl_oe && !oe_prev) pulses = pulses + 1;
    if (scl_oe) low_w = low_w + 1;
    if (!scl_oe && oe_prev) begin
      last_low = low_w;
      low_w = 0;
      if (hold_left > 0) hold_left = hold_left - 1;
    end
    if (eng_rst && !er_prev) rst_rises = rst_rises + 1;
    oe_prev = scl_oe;
    er_prev = eng_rst;
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    @(negedge clk); stat_we = 1'b1; stat_wdata = d;
    @(negedge clk); stat_we = 1'b0; stat_wdata = '0;
  endtask

  function automatic int exp_pulses(input int k);
    return (k > MAXP) ? MAXP : k;
  endfunction

  function automatic bit exp_ok(input int k);
    return k <= MAXP;
  endfunction

  task automatic run_rec(input int k);
    int guard;
    hold_left = k;
    cycles(4);
    pulses = 0; rst_rises = 0;
    @(negedge clk); recover_go = 1'b1;
    @(negedge clk); recover_go = 1'b0;
    guard = 0;
    while (rec_busy && guard < 1000) begin @(negedge clk); guard++; end
    cycles(3);
    check(pulses == exp_pulses(k), "R6/R7 pulse count", pulses, exp_pulses(k));
    check(rec_ok == exp_ok(k), "R6 rec_ok", rec_ok, exp_ok(k));
    check(rec_fail == !exp_ok(k), "R7 rec_fail", rec_fail, !exp_ok(k));
    check(rst_rises == (exp_ok(k) ? 1 : 0), "R8 engine reset pulses", rst_rises, exp_ok(k));
    if (k > 0) check(stat_rdata[0] == 1'b0, "R9 status cleared", stat_rdata[0], 0);
    hold_left = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c2b));
    cycles(3);
    rst = 1'b0;
    cycles(3);
    // R10 reset state
    check(scl_oe == 0 && eng_rst == 0, "R10 reset outputs", {scl_oe, eng_rst}, 0);
    check(ctrl_rdata[2:0] == 0 && stat_rdata == 0, "R10 reset regs", ctrl_rdata[2:0], 0);
    check(!rec_busy && !rec_ok && !rec_fail, "R10 reset flags", {rec_busy, rec_ok, rec_fail}, 0);

    // R4 monitor bits
    hold_left = 0; scl_ext = 1'b0; cycles(3);
    check(ctrl_rdata[4] == 1 && ctrl_rdata[3] == 0, "R4 monitor a", ctrl_rdata[4:3], 2);
    hold_left = 7; scl_ext = 1'b1; cycles(3);
    check(ctrl_rdata[4] == 0 && ctrl_rdata[3] == 1, "R4 monitor b", ctrl_rdata[4:3], 1);

    // R3 request with enable 0 is ignored
    pulses = 0;
    wr_ctrl(8'h04); cycles(2 * HALF + 4);
    check(pulses == 0, "R3 disabled request", pulses, 0);

    // R1 R2 R3 manual pulse, second request during the pulse
    hold_left = 7; pulses = 0;
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 8'h05;
    @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = '0;
    check(ctrl_rdata[2] == 1 && scl_oe == 1, "R2 request pending", {ctrl_rdata[2], scl_oe}, 3);
    wr_ctrl(8'h05);
    cycles(2 * HALF + 4);
    check(pulses == 1, "R1/R3 single pulse", pulses, 1);
    check(last_low == HALF, "R1 low width", last_low, HALF);
    check(ctrl_rdata[2] == 0, "R2 self clear", ctrl_rdata[2], 0);
    check(scl_oe == 0, "R10 released", scl_oe, 0);
    // R5 flag set with SDA low, cleared by writing 0
    check(stat_rdata[0] == 1, "R5 arb set", stat_rdata[0], 1);
    wr_stat(8'h00); cycles(1);
    check(stat_rdata[0] == 0, "R5 arb cleared", stat_rdata[0], 0);

    // R8 software engine reset bit
    wr_ctrl(8'h03); cycles(2);
    check(eng_rst == 1, "R8 sw reset on", eng_rst, 1);
    wr_ctrl(8'h01); cycles(2);
    check(eng_rst == 0, "R8 sw reset off", eng_rst, 0);

    // directed recovery corners
    run_rec(0);
    run_rec(1);
    run_rec(MAXP);
    run_rec(MAXP + 1);
    // random recoveries
    for (int i = 0; i < 10; i++) run_rec($urandom % 14);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule